// File: doc/BRIEF.md
# Windowed Block Address Generator

This block produces the memory byte address for one port of a field-buffer memory. Memory is organised as fixed-size blocks of bytes. In window mode the port walks a rectangle of blocks: a start block, a line width in blocks, a line count, and a line-to-line distance in blocks. That distance may be negative, so the lines are walked upward, which mirrors the picture vertically. An optional horizontal mirror walks each line backward from the line's first block, and the bytes inside each block are also walked backward. When window mode is off, the port behaves as a plain linear byte counter that wraps at the end of memory.

The port is driven by an advance strobe, which moves to the next address, and a pointer-reset pulse, which returns to the first address. The window settings are taken in only on the pointer-reset pulse, so software can reprogram them at any time without disturbing a window that is in progress. On a write port the block also decides whether the current advance stores data. In window mode a latched freeze bit makes this decision. In linear mode the external mask input makes it. The same module serves a read port when it is built with an unsigned stride and without mirroring.

Top module: `win_addr_gen`

## Requirements
- R1: After the global reset (rstN low), the port is in linear mode and addr is 0.
- R2: In linear mode, each cycle with advance high and ptrReset low adds 1 to addr. After the last byte of memory, addr wraps to 0.
- R3: A cycle with ptrReset high returns the pointer to the first address, even when advance is also high. In linear mode that address is 0. In window mode it is the start block with byte offset 0, or byte offset BLOCK_BYTES-1 under X-mirror. addr = block × BLOCK_BYTES + offset, where the offset sits in the low log2(BLOCK_BYTES) bits.
- R4: The mode, start, sizes, stride, mirror and freeze inputs take effect only in a cycle with ptrReset high. A change at any other time has no effect on addr or storeEn.
- R5: In window mode without mirror, each line visits blocks base, base+1, … base+xsize-1. Inside each block the offsets run from 0 up to BLOCK_BYTES-1.
- R6: Line n starts at block start + n×stride, taken modulo NUM_BLOCKS. When SIGNED_STRIDE=1, the stride is two's complement, so a negative stride moves upward through memory.
- R7: After the last byte of the last line (ysize lines), the next advance returns to the start block, offset as in R3.
- R8: Under X-mirror, each line visits blocks base, base-1, … base-xsize+1, modulo NUM_BLOCKS. Inside each block the offsets run from BLOCK_BYTES-1 down to 0.
- R9: An xsize of 0 is treated as one block, and a ysize of 0 is treated as one line.
- R10: When advance and ptrReset are both low, addr does not change.
- R11: storeEn is high only in a cycle with advance high and ptrReset low. In window mode it equals NOT the latched freeze bit, and maskIn is ignored. In linear mode it equals NOT maskIn, and the freeze bit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Global asynchronous reset, active low |
| ptrReset | input | 1 | Pointer reset pulse; also latches the settings |
| advance | input | 1 | Move to the next address |
| maskIn | input | 1 | External write mask, honoured in linear mode |
| cfgWinEn | input | 1 | Window mode select |
| cfgStart | input | BLK_W | Start block of the window |
| cfgXSize | input | XSIZE_W | Blocks per line |
| cfgStride | input | STRIDE_W | Line stride in blocks |
| cfgYSize | input | YSIZE_W | Lines per window |
| cfgXMirror | input | 1 | Reverse the order inside each line |
| cfgFreeze | input | 1 | Suppress storing in window mode |
| addr | output | ADDR_W | Current byte address |
| storeEn | output | 1 | Current advance stores data |

## Verification
The bench builds the block with 4-byte blocks, 64 blocks, 4-bit sizes and a signed 6-bit stride. With these values the linear wrap at byte 255 takes a few hundred cycles. Full windows, and two passes around them, finish in a few dozen steps. A negative stride from a low start block crosses block 0, so the modulo wrap of block numbers is exercised in both directions. Size-zero windows and mirror offsets counting down are covered by short runs.

// File: rtl/win_addr_pkg.sv
package win_addr_pkg;

  // Strobes from the sequencing control to the address datapath.
  typedef struct packed {
    logic load;      // pointer reset: latch settings, go to first address
    logic linStep;   // linear mode: advance the byte counter
    logic lineStep;  // window mode: move line base by one stride
    logic winWrap;   // window mode: line base back to start block
  } stepCtl_t;

endpackage

// File: rtl/win_addr_ctrl.sv
module win_addr_ctrl
  import win_addr_pkg::*;
#(
  parameter int BLOCK_BYTES = 64,
  parameter int XSIZE_W     = 10,
  parameter int YSIZE_W     = 16,
  localparam int OFF_W      = $clog2(BLOCK_BYTES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               ptrReset,
  input  logic               advance,
  input  logic               maskIn,
  input  logic               cfgWinEn,
  input  logic [XSIZE_W-1:0] cfgXSize,
  input  logic [YSIZE_W-1:0] cfgYSize,
  input  logic               cfgFreeze,
  output stepCtl_t           ctl,
  output logic               winMode,
  output logic [OFF_W-1:0]   byteOff,
  output logic [XSIZE_W-1:0] xCnt,
  output logic               storeEn
);

  logic [XSIZE_W-1:0] xLast;
  logic [YSIZE_W-1:0] yLast;
  logic [YSIZE_W-1:0] yCnt;
  logic               freezeL;

  logic endBlock, endLine, endWin, winAdv;

  assign endBlock = (byteOff == OFF_W'(BLOCK_BYTES - 1));
  assign endLine  = endBlock && (xCnt == xLast);
  assign endWin   = endLine && (yCnt == yLast);
  assign winAdv   = !ptrReset && advance && winMode;

  always_comb begin
    ctl          = '0;
    ctl.load     = ptrReset;
    ctl.linStep  = !ptrReset && advance && !winMode;
    ctl.lineStep = winAdv && endLine && !endWin;
    ctl.winWrap  = winAdv && endWin;
  end

  // In window mode the latched freeze decides; in linear mode the mask does.
  assign storeEn = advance && !ptrReset && (winMode ? !freezeL : !maskIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winMode <= 1'b0;
      xLast   <= '0;
      yLast   <= '0;
      freezeL <= 1'b0;
      byteOff <= '0;
      xCnt    <= '0;
      yCnt    <= '0;
    end else if (ptrReset) begin
      winMode <= cfgWinEn;
      xLast   <= (cfgXSize == '0) ? '0 : cfgXSize - 1'b1;
      yLast   <= (cfgYSize == '0) ? '0 : cfgYSize - 1'b1;
      freezeL <= cfgFreeze;
      byteOff <= '0;
      xCnt    <= '0;
      yCnt    <= '0;
    end else if (winAdv) begin
      byteOff <= byteOff + 1'b1;
      if (endBlock) begin
        xCnt <= endLine ? '0 : xCnt + 1'b1;
      end
      if (endLine) begin
        yCnt <= endWin ? '0 : yCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/win_addr_dp.sv
module win_addr_dp
  import win_addr_pkg::*;
#(
  parameter int BLOCK_BYTES   = 64,
  parameter int NUM_BLOCKS    = 8192,
  parameter int XSIZE_W       = 10,
  parameter int STRIDE_W      = 13,
  parameter bit SIGNED_STRIDE = 1'b1,
  parameter bit MIRROR_EN     = 1'b1,
  localparam int OFF_W        = $clog2(BLOCK_BYTES),
  localparam int BLK_W        = $clog2(NUM_BLOCKS),
  localparam int ADDR_W       = OFF_W + BLK_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  stepCtl_t            ctl,
  input  logic                winMode,
  input  logic [OFF_W-1:0]    byteOff,
  input  logic [XSIZE_W-1:0]  xCnt,
  input  logic [BLK_W-1:0]    cfgStart,
  input  logic [STRIDE_W-1:0] cfgStride,
  input  logic                cfgXMirror,
  output logic [ADDR_W-1:0]   addr
);

  logic [BLK_W-1:0]  strideExt;
  logic              mirrorIn;
  logic [BLK_W-1:0]  startL;
  logic [BLK_W-1:0]  strideL;
  logic              mirrorL;
  logic [BLK_W-1:0]  lineBase;
  logic [ADDR_W-1:0] linAddr;
  logic [BLK_W-1:0]  xExt;
  logic [BLK_W-1:0]  blkCur;
  logic [OFF_W-1:0]  offCur;

  // Stride variant: two's complement (write side) or unsigned (read side).
  generate
    if (SIGNED_STRIDE) begin : g_sstride
      assign strideExt = BLK_W'($signed(cfgStride));
    end else begin : g_ustride
      assign strideExt = BLK_W'(cfgStride);
    end
    if (MIRROR_EN) begin : g_mir
      assign mirrorIn = cfgXMirror;
    end else begin : g_nomir
      logic unusedMir;
      assign unusedMir = cfgXMirror;
      assign mirrorIn  = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startL   <= '0;
      strideL  <= '0;
      mirrorL  <= 1'b0;
      lineBase <= '0;
      linAddr  <= '0;
    end else begin
      if (ctl.load) begin
        startL   <= cfgStart;
        strideL  <= strideExt;
        mirrorL  <= mirrorIn;
        lineBase <= cfgStart;
        linAddr  <= '0;
      end else begin
        if (ctl.linStep)  linAddr  <= linAddr + 1'b1;
        if (ctl.lineStep) lineBase <= lineBase + strideL;
        if (ctl.winWrap)  lineBase <= startL;
      end
    end
  end

  // Block and offset arithmetic wraps naturally at the power-of-two sizes.
  assign xExt   = BLK_W'(xCnt);
  assign blkCur = mirrorL ? (lineBase - xExt) : (lineBase + xExt);
  assign offCur = mirrorL ? ~byteOff : byteOff;
  assign addr   = winMode ? {blkCur, offCur} : linAddr;

endmodule

// File: rtl/win_addr_gen.sv
module win_addr_gen
  import win_addr_pkg::*;
#(
  parameter int BLOCK_BYTES   = 64,
  parameter int NUM_BLOCKS    = 8192,
  parameter int XSIZE_W       = 10,
  parameter int YSIZE_W       = 16,
  parameter int STRIDE_W      = 13,
  parameter bit SIGNED_STRIDE = 1'b1,
  parameter bit MIRROR_EN     = 1'b1,
  localparam int OFF_W        = $clog2(BLOCK_BYTES),
  localparam int BLK_W        = $clog2(NUM_BLOCKS),
  localparam int ADDR_W       = OFF_W + BLK_W
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ptrReset,
  input  logic                advance,
  input  logic                maskIn,
  input  logic                cfgWinEn,
  input  logic [BLK_W-1:0]    cfgStart,
  input  logic [XSIZE_W-1:0]  cfgXSize,
  input  logic [STRIDE_W-1:0] cfgStride,
  input  logic [YSIZE_W-1:0]  cfgYSize,
  input  logic                cfgXMirror,
  input  logic                cfgFreeze,
  output logic [ADDR_W-1:0]   addr,
  output logic                storeEn
);

  stepCtl_t           ctl;
  logic               winMode;
  logic [OFF_W-1:0]   byteOff;
  logic [XSIZE_W-1:0] xCnt;

  win_addr_ctrl #(
    .BLOCK_BYTES(BLOCK_BYTES),
    .XSIZE_W    (XSIZE_W),
    .YSIZE_W    (YSIZE_W)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ptrReset (ptrReset),
    .advance  (advance),
    .maskIn   (maskIn),
    .cfgWinEn (cfgWinEn),
    .cfgXSize (cfgXSize),
    .cfgYSize (cfgYSize),
    .cfgFreeze(cfgFreeze),
    .ctl      (ctl),
    .winMode  (winMode),
    .byteOff  (byteOff),
    .xCnt     (xCnt),
    .storeEn  (storeEn)
  );

  win_addr_dp #(
    .BLOCK_BYTES  (BLOCK_BYTES),
    .NUM_BLOCKS   (NUM_BLOCKS),
    .XSIZE_W      (XSIZE_W),
    .STRIDE_W     (STRIDE_W),
    .SIGNED_STRIDE(SIGNED_STRIDE),
    .MIRROR_EN    (MIRROR_EN)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .winMode   (winMode),
    .byteOff   (byteOff),
    .xCnt      (xCnt),
    .cfgStart  (cfgStart),
    .cfgStride (cfgStride),
    .cfgXMirror(cfgXMirror),
    .addr      (addr)
  );

endmodule

// File: rtl/win_addr_checker.sv
module win_addr_checker #(
  parameter int BLOCK_BYTES   = 64,
  parameter int NUM_BLOCKS    = 8192,
  parameter int XSIZE_W       = 10,
  parameter int YSIZE_W       = 16,
  parameter int STRIDE_W      = 13,
  parameter bit SIGNED_STRIDE = 1'b1,
  parameter bit MIRROR_EN     = 1'b1,
  localparam int OFF_W        = $clog2(BLOCK_BYTES),
  localparam int BLK_W        = $clog2(NUM_BLOCKS),
  localparam int ADDR_W       = OFF_W + BLK_W
) (
  input logic                clk,
  input logic                rstN,
  input logic                ptrReset,
  input logic                advance,
  input logic                cfgWinEn,
  input logic [BLK_W-1:0]    cfgStart,
  input logic                cfgXMirror,
  input logic [ADDR_W-1:0]   addr,
  input logic                storeEn
);

  // Independent record of the mode taken in at the last pointer reset.
  logic modeWin, modeMir;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeWin <= 1'b0;
      modeMir <= 1'b0;
    end else if (ptrReset) begin
      modeWin <= cfgWinEn;
      modeMir <= cfgXMirror && MIRROR_EN;
    end
  end

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!advance && !ptrReset) |=> $stable(addr)); // R10

  AST_LIN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReset && !cfgWinEn) |=> (addr == '0)); // R3

  AST_WIN_RESET: assert property (@(posedge clk) disable iff (!rstN)
    (ptrReset && cfgWinEn) |=> (addr[ADDR_W-1:OFF_W] == $past(cfgStart))); // R3

  AST_LIN_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!modeWin && advance && !ptrReset) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R2

  AST_OFF_UP: assert property (@(posedge clk) disable iff (!rstN)
    (modeWin && !modeMir && advance && !ptrReset && (addr[OFF_W-1:0] != '1))
      |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R5

  AST_OFF_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (modeWin && modeMir && advance && !ptrReset && (addr[OFF_W-1:0] != '0))
      |=> (addr == ADDR_W'($past(addr) - 1'b1))); // R8

  AST_STORE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    storeEn |-> (advance && !ptrReset)); // R11

endmodule

bind win_addr_gen win_addr_checker #(
  .BLOCK_BYTES  (BLOCK_BYTES),
  .NUM_BLOCKS   (NUM_BLOCKS),
  .XSIZE_W      (XSIZE_W),
  .YSIZE_W      (YSIZE_W),
  .STRIDE_W     (STRIDE_W),
  .SIGNED_STRIDE(SIGNED_STRIDE),
  .MIRROR_EN    (MIRROR_EN)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ptrReset  (ptrReset),
  .advance   (advance),
  .cfgWinEn  (cfgWinEn),
  .cfgStart  (cfgStart),
  .cfgXMirror(cfgXMirror),
  .addr      (addr),
  .storeEn   (storeEn)
);

// File: tb/tb_win_addr_gen.sv
`timescale 1ns/1ps
module tb_win_addr_gen;

  localparam int BB     = 4;
  localparam int NB     = 64;
  localparam int XW     = 4;
  localparam int YW     = 4;
  localparam int SW     = 6;
  localparam int BLKW   = 6;
  localparam int AW     = 8;
  localparam int MEMSZ  = BB * NB;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ptrReset = 1'b0;
  logic          advance = 1'b0;
  logic          maskIn = 1'b0;
  logic          cfgWinEn = 1'b0;
  logic [BLKW-1:0] cfgStart = '0;
  logic [XW-1:0] cfgXSize = '0;
  logic [SW-1:0] cfgStride = '0;
  logic [YW-1:0] cfgYSize = '0;
  logic          cfgXMirror = 1'b0;
  logic          cfgFreeze = 1'b0;
  logic [AW-1:0] addr;
  logic          storeEn;

  win_addr_gen #(
    .BLOCK_BYTES(BB), .NUM_BLOCKS(NB), .XSIZE_W(XW), .YSIZE_W(YW),
    .STRIDE_W(SW), .SIGNED_STRIDE(1'b1), .MIRROR_EN(1'b1)
  ) dut (
    .clk(clk), .rstN(rstN), .ptrReset(ptrReset), .advance(advance),
    .maskIn(maskIn), .cfgWinEn(cfgWinEn), .cfgStart(cfgStart),
    .cfgXSize(cfgXSize), .cfgStride(cfgStride), .cfgYSize(cfgYSize),
    .cfgXMirror(cfgXMirror), .cfgFreeze(cfgFreeze),
    .addr(addr), .storeEn(storeEn)
  );

  always #4 clk = ~clk;  // 125 MHz

  int total = 0;
  int fails = 0;

  typedef struct {
    int    a;
    bit    s;
    string req;
  } exp_t;
  exp_t sbq[$];

  // Reference model state
  bit mWin, mMir, mFreeze;
  int mStart, mStride, mXl, mYl, mb, mx, my, mLin;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int modelAddr();
    int blk;
    int off;
    if (!mWin) return mLin;
    blk = mStart + my * mStride + (mMir ? -mx : mx);
    blk = ((blk % NB) + NB) % NB;
    off = mMir ? (BB - 1 - mb) : mb;
    return blk * BB + off;
  endfunction

  function automatic void modelStep();
    if (!mWin) begin
      mLin = (mLin + 1) % MEMSZ;
    end else begin
      mb++;
      if (mb == BB) begin
        mb = 0;
        if (mx == mXl) begin
          mx = 0;
          if (my == mYl) my = 0; else my++;
        end else mx++;
      end
    end
  endfunction

  // Pointer reset with new settings; the model takes them in at the same time.
  task automatic ptrLoad(input bit win, input int start, input int xs, input int stride,
                         input int ys, input bit mir, input bit frz, input bit withAdv);
    @(negedge clk);
    cfgWinEn = win; cfgStart = BLKW'(start); cfgXSize = XW'(xs);
    cfgStride = SW'(stride); cfgYSize = YW'(ys); cfgXMirror = mir; cfgFreeze = frz;
    ptrReset = 1'b1; advance = withAdv;
    mWin = win; mStart = start; mStride = stride; mMir = mir; mFreeze = frz;
    mXl = (xs == 0) ? 0 : xs - 1;
    mYl = (ys == 0) ? 0 : ys - 1;
    mb = 0; mx = 0; my = 0; mLin = 0;
    @(negedge clk);
    ptrReset = 1'b0; advance = 1'b0;
  endtask

  // Driver: push the expected address and store decision, then advance.
  task automatic steps(input int n, input bit mask, input string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      advance = 1'b1; maskIn = mask;
      sbq.push_back('{a: modelAddr(), s: (mWin ? !mFreeze : !mask), req: req});
      modelStep();
    end
    @(negedge clk);
    advance = 1'b0;
  endtask

  // Monitor: compare each advancing cycle against the queue.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (advance && !ptrReset && sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check({e.req, " addr"}, int'(addr), e.a);
        check({e.req, " storeEn"}, int'(storeEn), int'(e.s));
      end
    end
  end

  task automatic finish();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    #1_000_000;
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish();
  end

  initial begin
    mWin = 0; mMir = 0; mFreeze = 0; mStart = 0; mStride = 0;
    mXl = 0; mYl = 0; mb = 0; mx = 0; my = 0; mLin = 0;
    repeat (3) @(negedge clk);
    check("R1 reset addr", int'(addr), 0);
    check("R1 reset storeEn", int'(storeEn), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2: linear count through the end of memory and back to 0
    steps(MEMSZ + 6, 1'b0, "R2 linear");
    // R11: mask honoured in linear mode; freeze ignored there
    steps(4, 1'b1, "R11 linear mask");
    ptrLoad(1'b0, 9, 2, 3, 2, 1'b0, 1'b1, 1'b0);
    check("R3 linear reset addr", int'(addr), 0);
    steps(5, 1'b0, "R11 freeze ignored linear");

    // R5 R6 R7: plain window, two full passes
    ptrLoad(1'b1, 10, 3, 8, 2, 1'b0, 1'b0, 1'b0);
    check("R3 window first addr", int'(addr), 40);
    steps(2 * 3 * BB * 2, 1'b1, "R5 R6 R7 window");

    // R4: settings changed without a pointer reset have no effect
    @(negedge clk);
    cfgStart = 6'd40; cfgXSize = 4'd1; cfgXMirror = 1'b1; cfgWinEn = 1'b0; cfgFreeze = 1'b1;
    steps(20, 1'b0, "R4 no latch");

    // R10: idle cycles hold the address
    repeat (5) @(negedge clk);
    #1;
    check("R10 hold", int'(addr), modelAddr());

    // R3: pointer reset wins over a simultaneous advance
    ptrLoad(1'b1, 20, 2, 5, 3, 1'b0, 1'b0, 1'b1);
    #1;
    check("R3 reset over advance", int'(addr), 80);
    steps(7, 1'b0, "R3 restart");

    // R8 R6: X-mirror with negative stride crossing block 0
    ptrLoad(1'b1, 5, 3, -8, 3, 1'b1, 1'b0, 1'b0);
    #1;
    check("R8 mirror first addr", int'(addr), 5 * BB + BB - 1);
    steps(2 * 3 * BB * 3, 1'b0, "R8 R6 mirror ymirror");

    // R9: zero sizes become a one-block window at the last block
    ptrLoad(1'b1, 63, 0, 4, 0, 1'b0, 1'b0, 1'b0);
    steps(3 * BB, 1'b0, "R9 zero size");

    // R11: window mode, freeze overrides the mask
    ptrLoad(1'b1, 2, 2, 2, 2, 1'b0, 1'b1, 1'b0);
    steps(6, 1'b0, "R11 freeze window");
    ptrLoad(1'b1, 2, 2, 2, 2, 1'b0, 1'b0, 1'b0);
    steps(6, 1'b1, "R11 mask ignored window");

    repeat (3) @(negedge clk);
    check("R1 scoreboard drained", sbq.size(), 0);
    finish();
  end

endmodule